// File: doc/BRIEF.md
# Keyed-refresh watchdog timer

This block is a watchdog timer peripheral that sits on a simple register write/read port. A 16-bit counter advances on either every bus clock or on an alternate tick enable, and when it reaches the programmed timeout the block issues a one-cycle reset request to the system reset controller. Software keeps the system alive by writing two fixed 16-bit key words in a row to the counter address. A second, different pair of key words opens a short window in which the timeout and control registers can be changed.

Both key pairs are strict. The second word of a pair must follow the first within a bounded number of bus clocks. Any wrong word, any word out of order, and any pair left incomplete past that bound raises the reset request at once. Key words may arrive as one 16-bit write or as a high-byte write followed by a low-byte write. A debug input can freeze the counter and the key window timer, unless a control bit asks the watchdog to keep running during debug.

Register map (2-bit address): 0 = counter / key port, 1 = timeout, 2 = control A, 3 = control B.

Top module: `kwdt_top`

## Requirements
- R1: After the synchronous reset, the reset request is low, the count reads 0, the timeout reads 0xFFFF, control A and control B read 0, and configuration is locked.
- R2: Writing 0xA602 and then 0xB480 to address 0 clears the count. The first word alone leaves the count running.
- R3: The second key word is accepted when it arrives up to 16 bus clocks after the first. If no second word has arrived by the 17th bus clock, the reset request is raised in that cycle without any write.
- R4: At address 0, a word that is not the expected next key raises the reset request in the cycle after the write. This covers a stray value, 0xB480 with no pending pair, and 0xC520 after 0xA602.
- R5: Writing 0xC520 and then 0xD928 to address 0 opens a window of 128 bus clocks, starting the cycle after the second word. Writes to addresses 1 to 3 take effect only inside this window and are ignored otherwise, both at reset and after the window has closed.
- R6: Control A bit 7 enables counting. Control B bit 0 selects the counting source: 0 counts every bus clock, 1 counts only clocks where alt_tick is high.
- R7: With counting enabled, the reset request is raised once the count has reached the timeout, and the count is 0 in the cycle the request is seen. With bus-clock counting, requests repeat every timeout+1 cycles.
- R8: The reset request is never high for two cycles in a row. An expiry or violation in the cycle right after a request is absorbed.
- R9: Address 0 accepts byte writes. A high-byte write (wr_be = 2'b10) followed by a low-byte write (wr_be = 2'b01) forms one key word. A low-byte write with no staged high byte is a violation.
- R10: While dbg_mode is high and control A bit 2 is 0, the count and the key window timer hold their values. With bit 2 set, both keep running in debug.
- R11: A refresh that completes in the same cycle the count would expire wins: no reset request is issued and the count restarts from 0.
- R12: A read of address 0 returns the live count. All reads return data one clock after rd_addr is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write register address |
| wr_be | input | 2 | Byte enables, bit 1 high byte, bit 0 low byte |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 16 | Registered read data |
| alt_tick | input | 1 | Alternate counting enable, synchronous to clk |
| dbg_mode | input | 1 | Device is halted in debug |
| wdt_rst | output | 1 | One-cycle reset request |

## Verification
The collision of interest is between a completed refresh and a timeout expiry in the same clock. The bench programs a timeout of 4 with bus-clock counting and waits for one reset request to fix the phase of the counter. It then places the first key word one clock later and the second key word exactly in the clock where the count has reached 4. The refresh is judged correct if no request appears in that cycle, and if the next request comes exactly five clocks after the refresh, which shows the count restarted from 0 rather than from the expired value.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int DW = 16;
  localparam int AW = 2;

  localparam logic [DW-1:0] KEY_REF_A = 16'hA602;
  localparam logic [DW-1:0] KEY_REF_B = 16'hB480;
  localparam logic [DW-1:0] KEY_UNL_A = 16'hC520;
  localparam logic [DW-1:0] KEY_UNL_B = 16'hD928;

  localparam logic [AW-1:0] A_CNT = 2'd0;
  localparam logic [AW-1:0] A_TOV = 2'd1;
  localparam logic [AW-1:0] A_CSA = 2'd2;
  localparam logic [AW-1:0] A_CSB = 2'd3;

  localparam int CSA_EN  = 7;
  localparam int CSA_DBG = 2;
  localparam int CSB_ALT = 0;

  typedef enum logic [1:0] {KS_IDLE, KS_REF, KS_UNL} kseq_e;
endpackage

// File: rtl/kwdt_keyseq.sv
module kwdt_keyseq
  import kwdt_pkg::*;
#(
  parameter int WIN = 16,
  localparam int WW = $clog2(WIN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          key_wr,
  input  logic [1:0]    be,
  input  logic [DW-1:0] data,
  input  logic          stall,
  output logic          refresh,
  output logic          unlock,
  output logic          viol,
  output logic          waiting,
  output logic [WW-1:0] win
);
  kseq_e         st_q, st_d;
  logic [WW-1:0] win_q;
  logic          hi_vld_q;
  logic [7:0]    hi_q;
  logic          word_vld, bad_byte, late;
  logic [DW-1:0] word;

  always_comb begin
    word_vld = key_wr && ((be == 2'b11) || ((be == 2'b01) && hi_vld_q));
    bad_byte = key_wr && (be == 2'b01) && !hi_vld_q;
    word     = (be == 2'b11) ? data : {hi_q, data[7:0]};
    late     = (st_q != KS_IDLE) && (win_q >= WW'(WIN));
    st_d     = st_q;
    refresh  = 1'b0;
    unlock   = 1'b0;
    viol     = 1'b0;
    if (late || bad_byte) begin
      viol = 1'b1;
      st_d = KS_IDLE;
    end else if (word_vld) begin
      case (st_q)
        KS_IDLE: begin
          if (word == KEY_REF_A)      st_d = KS_REF;
          else if (word == KEY_UNL_A) st_d = KS_UNL;
          else                        viol = 1'b1;
        end
        KS_REF: begin
          st_d = KS_IDLE;
          if (word == KEY_REF_B) refresh = 1'b1;
          else                   viol    = 1'b1;
        end
        KS_UNL: begin
          st_d = KS_IDLE;
          if (word == KEY_UNL_B) unlock = 1'b1;
          else                   viol   = 1'b1;
        end
        default: begin
          st_d = KS_IDLE;
          viol = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= KS_IDLE;
      win_q    <= '0;
      hi_vld_q <= 1'b0;
      hi_q     <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == KS_IDLE) win_q <= '0;
      else if (!stall)     win_q <= win_q + 1'b1;
      if (key_wr && (be == 2'b10)) begin
        hi_vld_q <= 1'b1;
        hi_q     <= data[15:8];
      end else if (key_wr && be[0]) begin
        hi_vld_q <= 1'b0;
      end
    end
  end

  assign waiting = (st_q != KS_IDLE);
  assign win     = win_q;
endmodule

// File: rtl/kwdt_cfg.sv
module kwdt_cfg
  import kwdt_pkg::*;
#(
  parameter int            CFG_WIN = 128,
  parameter logic [DW-1:0] TOV_RST = 16'hFFFF,
  localparam int           OW      = $clog2(CFG_WIN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          unlock,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [1:0]    be,
  input  logic [DW-1:0] data,
  output logic [DW-1:0] tov,
  output logic          en,
  output logic          dbg_act,
  output logic          alt_sel,
  output logic          open
);
  logic [OW-1:0] left_q;
  logic          acc;

  assign open = (left_q != '0);
  assign acc  = wr_en && open;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      tov     <= TOV_RST;
      en      <= 1'b0;
      dbg_act <= 1'b0;
      alt_sel <= 1'b0;
    end else begin
      if (unlock)    left_q <= OW'(CFG_WIN);
      else if (open) left_q <= left_q - 1'b1;
      if (acc && (wr_addr == A_TOV)) begin
        if (be[1]) tov[15:8] <= data[15:8];
        if (be[0]) tov[7:0]  <= data[7:0];
      end
      if (acc && (wr_addr == A_CSA) && be[0]) begin
        en      <= data[CSA_EN];
        dbg_act <= data[CSA_DBG];
      end
      if (acc && (wr_addr == A_CSB) && be[0]) alt_sel <= data[CSB_ALT];
    end
  end
endmodule

// File: rtl/kwdt_count.sv
module kwdt_count
  import kwdt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic          stall,
  input  logic          clr,
  input  logic [DW-1:0] tov,
  output logic [DW-1:0] cnt,
  output logic          expire
);
  assign expire = en && !stall && (cnt >= tov);

  always_ff @(posedge clk) begin
    if (rst)                                       cnt <= '0;
    else if (clr)                                  cnt <= '0;
    else if (en && tick && !stall && (cnt != '1))  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int            WIN     = 16,
  parameter int            CFG_WIN = 128,
  parameter logic [DW-1:0] TOV_RST = 16'hFFFF,
  localparam int           WW      = $clog2(WIN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [1:0]    wr_be,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          alt_tick,
  input  logic          dbg_mode,
  output logic          wdt_rst
);
  logic          refresh, unlock, viol, waiting;
  logic [WW-1:0] win;
  logic [DW-1:0] tov, cnt;
  logic          en, dbg_act, alt_sel, cfg_open;
  logic          stall, tick, expire, pulse_now, key_wr;

  assign stall     = dbg_mode && !dbg_act;
  assign tick      = alt_sel ? alt_tick : 1'b1;
  assign key_wr    = wr_en && (wr_addr == A_CNT);
  // a refresh landing on the expiry cycle wins; nothing stacks on a pulse
  assign pulse_now = (viol || (expire && !refresh)) && !wdt_rst;

  kwdt_keyseq #(.WIN(WIN)) u_key (
    .clk(clk), .rst(rst), .key_wr(key_wr), .be(wr_be), .data(wr_data),
    .stall(stall), .refresh(refresh), .unlock(unlock), .viol(viol),
    .waiting(waiting), .win(win)
  );

  kwdt_cfg #(.CFG_WIN(CFG_WIN), .TOV_RST(TOV_RST)) u_cfg (
    .clk(clk), .rst(rst), .unlock(unlock), .wr_en(wr_en), .wr_addr(wr_addr),
    .be(wr_be), .data(wr_data), .tov(tov), .en(en), .dbg_act(dbg_act),
    .alt_sel(alt_sel), .open(cfg_open)
  );

  kwdt_count u_cnt (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .stall(stall),
    .clr(refresh || pulse_now), .tov(tov), .cnt(cnt), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wdt_rst <= 1'b0;
      rd_data <= '0;
    end else begin
      wdt_rst <= pulse_now;
      case (rd_addr)
        A_CNT:   rd_data <= cnt;
        A_TOV:   rd_data <= tov;
        A_CSA:   rd_data <= {8'h00, en, 4'b0000, dbg_act, 2'b00};
        default: rd_data <= {15'd0, alt_sel};
      endcase
    end
  end
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk
  import kwdt_pkg::*;
#(
  parameter int  WIN = 16,
  localparam int WW  = $clog2(WIN + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [1:0]    wr_be,
  input logic [DW-1:0] wr_data,
  input logic          dbg_mode,
  input logic          wdt_rst,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] tov,
  input logic          cfg_open,
  input logic          dbg_act,
  input logic          refresh,
  input logic          waiting,
  input logic [WW-1:0] win
);
  AST_REFRESH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    refresh |=> (cnt == '0)); // R2

  AST_KEY_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
    (waiting && (win >= WW'(WIN)) && !wdt_rst) |=> wdt_rst); // R3

  AST_BAD_WORD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr == A_CNT) && (wr_be == 2'b11) && !waiting && !wdt_rst &&
     (wr_data != KEY_REF_A) && (wr_data != KEY_UNL_A)) |=> wdt_rst); // R4

  AST_LOCKED_TOV: assert property (@(posedge clk) disable iff (rst)
    !cfg_open |=> $stable(tov)); // R5

  AST_CNT_ZERO_ON_PULSE: assert property (@(posedge clk) disable iff (rst)
    wdt_rst |-> (cnt == '0)); // R7

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wdt_rst |=> !wdt_rst); // R8

  AST_DEBUG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (dbg_mode && !dbg_act && !refresh) |=> ($stable(cnt) || wdt_rst)); // R10
endmodule

bind kwdt_top kwdt_chk #(.WIN(WIN)) i_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
  .wr_data(wr_data), .dbg_mode(dbg_mode), .wdt_rst(wdt_rst), .cnt(cnt),
  .tov(tov), .cfg_open(cfg_open), .dbg_act(dbg_act), .refresh(refresh),
  .waiting(waiting), .win(win)
);

// File: tb/test_kwdt_top.sv
`timescale 1ns/1ps
module test_kwdt_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [1:0]  wr_be = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        alt_tick = 1'b0;
  logic        dbg_mode = 1'b0;
  logic        wdt_rst;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  kwdt_top i_kwdt_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .alt_tick(alt_tick), .dbg_mode(dbg_mode), .wdt_rst(wdt_rst)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] be, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wr_be = 2'b00;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    rd_addr = a;
    @(posedge clk); @(negedge clk);
    v = rd_data;
  endtask

  task automatic do_unlock();
    wr(2'd0, 2'b11, 16'hC520);
    wr(2'd0, 2'b11, 16'hD928);
  endtask

  task automatic do_refresh();
    wr(2'd0, 2'b11, 16'hA602);
    wr(2'd0, 2'b11, 16'hB480);
  endtask

  task automatic wait_pulse(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); @(negedge clk);
      if (wdt_rst) begin seen = 1'b1; break; end
    end
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk(wdt_rst == 1'b0, "R1 request low", 16'(wdt_rst), 16'h0);
    rd(2'd0, v); chk(v == 16'h0000, "R1 count", v, 16'h0000);
    rd(2'd1, v); chk(v == 16'hFFFF, "R1 timeout", v, 16'hFFFF);
    rd(2'd2, v); chk(v == 16'h0000, "R1 control A", v, 16'h0000);
    rd(2'd3, v); chk(v == 16'h0000, "R1 control B", v, 16'h0000);
  endtask

  task automatic t_locked();
    logic [15:0] v;
    wr(2'd1, 2'b11, 16'h1234);
    wr(2'd2, 2'b01, 16'h0080);
    rd(2'd1, v); chk(v == 16'hFFFF, "R5 locked timeout", v, 16'hFFFF);
    rd(2'd2, v); chk(v == 16'h0000, "R5 locked control", v, 16'h0000);
  endtask

  task automatic t_window_edge();
    logic [15:0] v;
    do_unlock();
    idle(127);
    wr(2'd1, 2'b11, 16'h0010);
    wr(2'd1, 2'b11, 16'h0020);
    rd(2'd1, v); chk(v == 16'h0010, "R5 window last cycle / closed", v, 16'h0010);
  endtask

  task automatic t_config();
    logic [15:0] v;
    do_unlock();
    wr(2'd1, 2'b11, 16'h0100);
    wr(2'd3, 2'b01, 16'h0000);
    wr(2'd2, 2'b01, 16'h0080);
    rd(2'd2, v); chk(v == 16'h0080, "R6 enable bit", v, 16'h0080);
    rd(2'd1, v); chk(v == 16'h0100, "R5 timeout written", v, 16'h0100);
  endtask

  task automatic t_live_count();
    logic [15:0] a, b;
    do_refresh();
    rd(2'd0, a);
    rd(2'd0, b);
    chk(b == a + 16'd1, "R12 live count R6 bus clock", b, a + 16'd1);
  endtask

  task automatic t_refresh();
    logic [15:0] v;
    do_refresh();
    idle(3);
    wr(2'd0, 2'b11, 16'hA602);
    rd(2'd0, v); chk(v != 16'h0000, "R2 first word keeps count", v, 16'h0001);
    wr(2'd0, 2'b11, 16'hB480);
    chk(wdt_rst == 1'b0, "R2 no request", 16'(wdt_rst), 16'h0);
    rd(2'd0, v); chk(v == 16'h0000, "R2 count cleared", v, 16'h0000);
  endtask

  task automatic t_window();
    logic [15:0] v;
    bit hit;
    do_refresh();
    wr(2'd0, 2'b11, 16'hA602);
    idle(15);
    wr(2'd0, 2'b11, 16'hB480);
    chk(wdt_rst == 1'b0, "R3 second word at 16 clocks", 16'(wdt_rst), 16'h0);
    rd(2'd0, v); chk(v == 16'h0000, "R3 late-edge refresh clears", v, 16'h0000);
    wr(2'd0, 2'b11, 16'hA602);
    hit = 1'b0;
    for (int i = 0; i < 16; i++) begin
      idle(1);
      if (wdt_rst) hit = 1'b1;
    end
    chk(hit == 1'b0, "R3 quiet through 16 clocks", 16'(hit), 16'h0);
    idle(1);
    chk(wdt_rst == 1'b1, "R3 request at 17th clock", 16'(wdt_rst), 16'h1);
  endtask

  task automatic t_bad_words();
    idle(1);
    wr(2'd0, 2'b11, 16'h1234);
    chk(wdt_rst == 1'b1, "R4 stray word", 16'(wdt_rst), 16'h1);
    idle(1);
    wr(2'd0, 2'b11, 16'hB480);
    chk(wdt_rst == 1'b1, "R4 second word first", 16'(wdt_rst), 16'h1);
    idle(1);
    wr(2'd0, 2'b11, 16'hA602);
    chk(wdt_rst == 1'b0, "R4 valid first word", 16'(wdt_rst), 16'h0);
    wr(2'd0, 2'b11, 16'hC520);
    chk(wdt_rst == 1'b1, "R4 mixed pair", 16'(wdt_rst), 16'h1);
    idle(1);
  endtask

  task automatic t_bytes();
    logic [15:0] v;
    do_refresh();
    idle(4);
    wr(2'd0, 2'b10, 16'hA600);
    wr(2'd0, 2'b01, 16'h0002);
    wr(2'd0, 2'b10, 16'hB400);
    wr(2'd0, 2'b01, 16'h0080);
    chk(wdt_rst == 1'b0, "R9 byte-wise refresh", 16'(wdt_rst), 16'h0);
    rd(2'd0, v); chk(v == 16'h0000, "R9 byte-wise clears", v, 16'h0000);
    wr(2'd0, 2'b01, 16'h0002);
    chk(wdt_rst == 1'b1, "R9 lone low byte", 16'(wdt_rst), 16'h1);
    idle(1);
  endtask

  task automatic t_collision();
    bit seen, hit;
    do_unlock();
    wr(2'd1, 2'b11, 16'h0004);
    wait_pulse(seen);
    chk(seen == 1'b1, "R7 expiry at timeout", 16'(seen), 16'h1);
    wr(2'd0, 2'b11, 16'hA602);
    idle(3);
    wr(2'd0, 2'b11, 16'hB480);
    chk(wdt_rst == 1'b0, "R11 refresh beats expiry", 16'(wdt_rst), 16'h0);
    hit = 1'b0;
    for (int i = 0; i < 4; i++) begin
      idle(1);
      if (wdt_rst) hit = 1'b1;
    end
    chk(hit == 1'b0, "R11 count restarted", 16'(hit), 16'h0);
    idle(1);
    chk(wdt_rst == 1'b1, "R7 period timeout+1", 16'(wdt_rst), 16'h1);
    idle(1);
    chk(wdt_rst == 1'b0, "R8 single-cycle request", 16'(wdt_rst), 16'h0);
  endtask

  task automatic t_debug();
    logic [15:0] a, b;
    bit hit, seen;
    dbg_mode = 1'b1;
    hit = 1'b0;
    for (int i = 0; i < 20; i++) begin
      idle(1);
      if (wdt_rst) hit = 1'b1;
    end
    chk(hit == 1'b0, "R10 no expiry in debug", 16'(hit), 16'h0);
    rd(2'd0, a);
    rd(2'd0, b);
    chk(a == b, "R10 count held", b, a);
    wr(2'd0, 2'b11, 16'hA602);
    hit = 1'b0;
    for (int i = 0; i < 30; i++) begin
      idle(1);
      if (wdt_rst) hit = 1'b1;
    end
    wr(2'd0, 2'b11, 16'hB480);
    if (wdt_rst) hit = 1'b1;
    chk(hit == 1'b0, "R10 key window held", 16'(hit), 16'h0);
    do_unlock();
    wr(2'd2, 2'b01, 16'h0084);
    wait_pulse(seen);
    chk(seen == 1'b1, "R10 runs with debug bit set", 16'(seen), 16'h1);
    dbg_mode = 1'b0;
    idle(1);
  endtask

  task automatic t_alt_clock();
    logic [15:0] a, b;
    do_unlock();
    wr(2'd3, 2'b01, 16'h0001);
    idle(1);
    do_refresh();
    rd(2'd0, a);
    rd(2'd0, b);
    chk((a == 16'h0000) && (b == 16'h0000), "R6 no tick no count", b, 16'h0000);
    alt_tick = 1'b1;
    idle(3);
    alt_tick = 1'b0;
    rd(2'd0, a);
    chk(a == 16'h0003, "R6 counts alternate ticks", a, 16'h0003);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_locked();
    t_window_edge();
    t_config();
    t_live_count();
    t_refresh();
    t_window();
    t_bad_words();
    t_bytes();
    t_collision();
    t_debug();
    t_alt_clock();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule